// File: doc/BRIEF.md
# Mesh Walk Controller with Vertex Output DMA

This block steps an external program through every point of a two-dimensional mesh. For each point it writes the column index into general register 0 and the row index into general register 1. It then pulses a restart so the program begins again at instruction 0, and waits. The program either reports one vector-output event carrying two 32-bit words, or it runs out of its instruction allowance.

For each vector output, the controller computes a memory address from the mesh base and the point's coordinates. It sends the two words, byte-swapped to big-endian order, to the address and to the address plus 4, over a valid/ready write port. When the last point is finished, it records the vertex count and pulses an interrupt.

Software sets the base address and the last column and row indices through a small word-addressed register interface. It starts a walk by setting bit 0 of the control register. While the walk runs, that bit reads back as busy.

Top module: `mesh_walk`

## Requirements
- R1: Writing word index 0 with bit 0 set while idle starts a walk, and bit 0 of index 0 reads 1 from the next cycle until the interrupt pulse has gone. A start write made while a walk is running has no effect: the walk visits each point once and pulses the interrupt once.
- R2: Rows are the outer loop and columns the inner loop. Row runs from 0 to the last row index inclusive, and column from 0 to the last column index inclusive; each point is visited exactly once.
- R3: For each point the block writes the column to general register 0 (gpr_idx=0), then the row to general register 1 (gpr_idx=1) in the next cycle, and pulses prog_go in the cycle after that.
- R4: A vector output produces two write beats. The first goes to base + 8*(128*row + column) with the first word byte-reversed ({w[7:0],w[15:8],w[23:16],w[31:24]}). The second goes to that address + 4 with the second word byte-reversed.
- R5: Register index 5 (last output) holds the output address + 4 of the most recent vector output, once its second beat is accepted.
- R6: At the end of a walk, register index 4 (vertex count) becomes (last column + 1) * (last row + 1), and irq is high for exactly one cycle.
- R7: If a point retires 2048 instructions (prog_step pulses) without a vector output, the point produces no write and the walk moves on to the next point.
- R8: Reset clears every register to zero. The word map is: index 0 control, index 1 base, index 2 last column, index 3 last row, index 4 vertex count, index 5 last output. Indices 4 and 5 ignore writes, and any other index reads 0.
- R9: While dma_valid is high and dma_ready is low, dma_valid, dma_addr and dma_data hold steady and the walk does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| gpr_we | output | 1 | General register write strobe toward the program |
| gpr_idx | output | 1 | General register number (0 column, 1 row) |
| gpr_wdata | output | 32 | Coordinate value, zero-extended |
| prog_go | output | 1 | Restart pulse: program counter to 0 |
| prog_step | input | 1 | One instruction retired |
| prog_vec | input | 1 | Vector output event; ends the point |
| vec_a | input | 32 | First word of the vector output |
| vec_b | input | 32 | Second word of the vector output |
| dma_valid | output | 1 | Write beat valid |
| dma_ready | input | 1 | Write beat accepted |
| dma_addr | output | 32 | Write byte address |
| dma_data | output | 32 | Write data, big-endian byte order |
| irq | output | 1 | One-cycle pulse at walk completion |

## Verification
The busy bit is due one clock edge after the start write. For each point, the column write, the row write and prog_go come on three consecutive cycles. The first write beat is offered one edge after the edge that samples prog_vec. The second beat follows one edge after the first is accepted, and irq comes two edges after the last beat, or after the cut-off step of the last point. The bench drives and logs on falling edges, so each beat and register write is recorded in the cycle before the rising edge that takes it. Vertex count, last output and the busy bit are read only after irq has been seen and a margin of cycles has passed. A cut-off point is checked by the absence of its beats from an otherwise ordered log.

// File: rtl/mw_pkg.sv
package mw_pkg;

    localparam int WORD_W = 32;

    localparam int IDX_CTRL    = 0;
    localparam int IDX_BASE    = 1;
    localparam int IDX_COLLAST = 2;
    localparam int IDX_ROWLAST = 3;
    localparam int IDX_VCOUNT  = 4;
    localparam int IDX_LASTOUT = 5;

    typedef enum logic [3:0] {
        WS_IDLE,
        WS_LOAD_COL,
        WS_LOAD_ROW,
        WS_KICK,
        WS_RUN,
        WS_BEAT0,
        WS_BEAT1,
        WS_ADVANCE,
        WS_FINISH
    } walk_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] first;
        logic [WORD_W-1:0] second;
    } vec_pair_t;

    function automatic logic [WORD_W-1:0] to_big_endian(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < WORD_W/8; i++) begin
            r[8*i +: 8] = w[WORD_W-8-8*i +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/mw_regs.sv
module mw_regs
    import mw_pkg::*;
#(
    parameter int AW = 3,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic              busy,
    input  logic              finish,
    input  logic [WORD_W-1:0] vcount_val,
    input  logic              out_done,
    input  logic [WORD_W-1:0] out_addr,
    output logic              start_req,
    output logic [WORD_W-1:0] base,
    output logic [CW-1:0]     col_last,
    output logic [CW-1:0]     row_last
);

    logic [WORD_W-1:0] vcount_q;
    logic [WORD_W-1:0] lastout_q;

    assign start_req = wr_en && (addr == AW'(IDX_CTRL)) && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            base      <= '0;
            col_last  <= '0;
            row_last  <= '0;
            vcount_q  <= '0;
            lastout_q <= '0;
        end else begin
            if (wr_en) begin
                case (addr)
                    AW'(IDX_BASE):    base     <= wdata;
                    AW'(IDX_COLLAST): col_last <= wdata[CW-1:0];
                    AW'(IDX_ROWLAST): row_last <= wdata[CW-1:0];
                    default: ;
                endcase
            end
            if (finish)   vcount_q  <= vcount_val;
            if (out_done) lastout_q <= out_addr;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            AW'(IDX_CTRL):    rdata = {{(WORD_W-1){1'b0}}, busy};
            AW'(IDX_BASE):    rdata = base;
            AW'(IDX_COLLAST): rdata = WORD_W'(col_last);
            AW'(IDX_ROWLAST): rdata = WORD_W'(row_last);
            AW'(IDX_VCOUNT):  rdata = vcount_q;
            AW'(IDX_LASTOUT): rdata = lastout_q;
            default:          rdata = '0;
        endcase
    end

endmodule

// File: rtl/mw_seq.sv
module mw_seq
    import mw_pkg::*;
#(
    parameter int CW        = 16,
    parameter int MAX_STEPS = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic [CW-1:0]     col_last,
    input  logic [CW-1:0]     row_last,
    input  logic              prog_step,
    input  logic              prog_vec,
    input  logic [WORD_W-1:0] vec_a,
    input  logic [WORD_W-1:0] vec_b,
    input  logic              dma_ready,
    output logic              busy,
    output logic [CW-1:0]     cur_col,
    output logic [CW-1:0]     cur_row,
    output logic              gpr_we,
    output logic              gpr_idx,
    output logic [WORD_W-1:0] gpr_wdata,
    output logic              prog_go,
    output logic              dma_valid,
    output logic              second_beat,
    output vec_pair_t         words,
    output logic              out_done,
    output logic              finish,
    output logic [WORD_W-1:0] vcount_val
);

    localparam int SW = $clog2(MAX_STEPS + 1);

    walk_state_e state_q;
    logic [SW-1:0] steps_q;
    logic [WORD_W-1:0] col_n, row_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WS_IDLE;
            cur_col <= '0;
            cur_row <= '0;
            steps_q <= '0;
            words   <= '0;
        end else begin
            case (state_q)
                WS_IDLE: if (start_req) begin
                    cur_col <= '0;
                    cur_row <= '0;
                    state_q <= WS_LOAD_COL;
                end
                WS_LOAD_COL: state_q <= WS_LOAD_ROW;
                WS_LOAD_ROW: state_q <= WS_KICK;
                WS_KICK: begin
                    steps_q <= '0;
                    state_q <= WS_RUN;
                end
                WS_RUN: begin
                    if (prog_vec) begin
                        words.first  <= vec_a;
                        words.second <= vec_b;
                        state_q      <= WS_BEAT0;
                    end else if (prog_step) begin
                        if (steps_q == SW'(MAX_STEPS - 1)) state_q <= WS_ADVANCE;
                        else steps_q <= steps_q + 1'b1;
                    end
                end
                WS_BEAT0: if (dma_ready) state_q <= WS_BEAT1;
                WS_BEAT1: if (dma_ready) state_q <= WS_ADVANCE;
                WS_ADVANCE: begin
                    if (cur_col == col_last) begin
                        cur_col <= '0;
                        if (cur_row == row_last) begin
                            state_q <= WS_FINISH;
                        end else begin
                            cur_row <= cur_row + 1'b1;
                            state_q <= WS_LOAD_COL;
                        end
                    end else begin
                        cur_col <= cur_col + 1'b1;
                        state_q <= WS_LOAD_COL;
                    end
                end
                WS_FINISH: state_q <= WS_IDLE;
                default:   state_q <= WS_IDLE;
            endcase
        end
    end

    always_comb begin
        busy        = (state_q != WS_IDLE);
        gpr_we      = (state_q == WS_LOAD_COL) || (state_q == WS_LOAD_ROW);
        gpr_idx     = (state_q == WS_LOAD_ROW);
        gpr_wdata   = gpr_idx ? WORD_W'(cur_row) : WORD_W'(cur_col);
        prog_go     = (state_q == WS_KICK);
        dma_valid   = (state_q == WS_BEAT0) || (state_q == WS_BEAT1);
        second_beat = (state_q == WS_BEAT1);
        out_done    = (state_q == WS_BEAT1) && dma_ready;
        finish      = (state_q == WS_FINISH);
        col_n       = WORD_W'(col_last) + WORD_W'(1);
        row_n       = WORD_W'(row_last) + WORD_W'(1);
        vcount_val  = col_n * row_n;
    end

endmodule

// File: rtl/mw_addr.sv
module mw_addr
    import mw_pkg::*;
#(
    parameter int CW     = 16,
    parameter int STRIDE = 128
) (
    input  logic [WORD_W-1:0] base,
    input  logic [CW-1:0]     cur_col,
    input  logic [CW-1:0]     cur_row,
    input  logic              second_beat,
    input  vec_pair_t         words,
    output logic [WORD_W-1:0] dma_addr,
    output logic [WORD_W-1:0] dma_data
);

    localparam int BYTES_PER_POINT = 2 * (WORD_W / 8);

    logic [WORD_W-1:0] linear;
    logic [WORD_W-1:0] point_addr;

    always_comb begin
        linear     = WORD_W'(cur_row) * WORD_W'(STRIDE) + WORD_W'(cur_col);
        point_addr = base + linear * WORD_W'(BYTES_PER_POINT);
        dma_addr   = second_beat ? point_addr + WORD_W'(WORD_W / 8) : point_addr;
        dma_data   = second_beat ? to_big_endian(words.second) : to_big_endian(words.first);
    end

endmodule

// File: rtl/mesh_walk.sv
module mesh_walk
    import mw_pkg::*;
#(
    parameter int AW        = 3,
    parameter int CW        = 16,
    parameter int STRIDE    = 128,
    parameter int MAX_STEPS = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              gpr_we,
    output logic              gpr_idx,
    output logic [WORD_W-1:0] gpr_wdata,
    output logic              prog_go,
    input  logic              prog_step,
    input  logic              prog_vec,
    input  logic [WORD_W-1:0] vec_a,
    input  logic [WORD_W-1:0] vec_b,
    output logic              dma_valid,
    input  logic              dma_ready,
    output logic [WORD_W-1:0] dma_addr,
    output logic [WORD_W-1:0] dma_data,
    output logic              irq
);

    logic              busy, start_req, finish, out_done, second_beat;
    logic [WORD_W-1:0] base, vcount_val;
    logic [CW-1:0]     col_last, row_last, cur_col, cur_row;
    vec_pair_t         words;

    mw_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .busy(busy), .finish(finish), .vcount_val(vcount_val),
        .out_done(out_done), .out_addr(dma_addr), .start_req(start_req),
        .base(base), .col_last(col_last), .row_last(row_last)
    );

    mw_seq #(.CW(CW), .MAX_STEPS(MAX_STEPS)) u_seq (
        .clk(clk), .rst(rst), .start_req(start_req), .col_last(col_last),
        .row_last(row_last), .prog_step(prog_step), .prog_vec(prog_vec),
        .vec_a(vec_a), .vec_b(vec_b), .dma_ready(dma_ready), .busy(busy),
        .cur_col(cur_col), .cur_row(cur_row), .gpr_we(gpr_we), .gpr_idx(gpr_idx),
        .gpr_wdata(gpr_wdata), .prog_go(prog_go), .dma_valid(dma_valid),
        .second_beat(second_beat), .words(words), .out_done(out_done),
        .finish(finish), .vcount_val(vcount_val)
    );

    mw_addr #(.CW(CW), .STRIDE(STRIDE)) u_addr (
        .base(base), .cur_col(cur_col), .cur_row(cur_row), .second_beat(second_beat),
        .words(words), .dma_addr(dma_addr), .dma_data(dma_data)
    );

    assign irq = finish;

endmodule

// File: rtl/mesh_walk_chk.sv
module mesh_walk_chk #(
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_wr,
    input logic [AW-1:0] reg_addr,
    input logic [31:0]   reg_wdata,
    input logic          busy,
    input logic          gpr_we,
    input logic          gpr_idx,
    input logic          prog_go,
    input logic          dma_valid,
    input logic          dma_ready,
    input logic [31:0]   dma_addr,
    input logic [31:0]   dma_data,
    input logic          irq
);

    AST_START_TAKES: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == '0 && reg_wdata[0] && !busy) |=> busy); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!gpr_we && !prog_go && !dma_valid && !irq)); // R1

    AST_ROW_AFTER_COL: assert property (@(posedge clk) disable iff (rst)
        (gpr_we && !gpr_idx) |=> (gpr_we && gpr_idx)); // R3

    AST_GO_AFTER_ROW: assert property (@(posedge clk) disable iff (rst)
        (gpr_we && gpr_idx) |=> prog_go); // R3

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R6

    AST_BEAT_HELD: assert property (@(posedge clk) disable iff (rst)
        (dma_valid && !dma_ready) |=> (dma_valid && $stable(dma_addr) && $stable(dma_data))); // R9

endmodule

bind mesh_walk mesh_walk_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .busy(busy), .gpr_we(gpr_we), .gpr_idx(gpr_idx), .prog_go(prog_go),
    .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_addr(dma_addr),
    .dma_data(dma_data), .irq(irq)
);

// File: tb/mesh_walk_tb.sv
module mesh_walk_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        gpr_we, gpr_idx, prog_go, dma_valid, irq;
    logic [31:0] gpr_wdata, dma_addr, dma_data;
    logic        prog_step = 1'b0, prog_vec = 1'b0, dma_ready = 1'b1;
    logic [31:0] vec_a = '0, vec_b = '0;

    always #2 clk = ~clk;

    mesh_walk u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .gpr_we(gpr_we), .gpr_idx(gpr_idx), .gpr_wdata(gpr_wdata),
        .prog_go(prog_go), .prog_step(prog_step), .prog_vec(prog_vec), .vec_a(vec_a),
        .vec_b(vec_b), .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_addr(dma_addr),
        .dma_data(dma_data), .irq(irq)
    );

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    logic [31:0] gl_data [0:63];
    logic        gl_idx  [0:63];
    int          gl_n = 0;
    logic [31:0] dl_addr [0:63];
    logic [31:0] dl_data [0:63];
    int          dl_n = 0;
    int          irq_cnt = 0, go_cnt = 0;
    bit          armed = 0, stall = 0;
    int          step_cnt = 0, pt_idx = 0, skip_pt = -1, steps_cfg = 0;
    logic [31:0] g_col = '0, g_row = '0;

    function automatic logic [31:0] word_a(input int x, input int y);
        return 32'hC0DE_0000 ^ (32'(x & 255) << 8) ^ 32'(y & 255);
    endfunction

    function automatic logic [31:0] swapped(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // program stand-in, write sink and logger, all on the falling edge
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
        dma_ready = stall ? (cyc % 3 == 0) : 1'b1;
        prog_step = 1'b0;
        prog_vec  = 1'b0;
        if (armed) begin
            if (pt_idx == skip_pt || step_cnt < steps_cfg) begin
                prog_step = 1'b1;
                step_cnt++;
            end else begin
                prog_vec = 1'b1;
                vec_a    = word_a(int'(g_col), int'(g_row));
                vec_b    = ~word_a(int'(g_col), int'(g_row));
                armed    = 0;
            end
        end
        if (!rst) begin
            if (prog_go) begin
                armed    = 1;
                step_cnt = 0;
                pt_idx   = go_cnt;
                go_cnt++;
            end
            if (gpr_we) begin
                if (gpr_idx) g_row = gpr_wdata;
                else         g_col = gpr_wdata;
                if (gl_n < 64) begin
                    gl_data[gl_n] = gpr_wdata;
                    gl_idx[gl_n]  = gpr_idx;
                    gl_n++;
                end
            end
            if (dma_valid && dma_ready && dl_n < 64) begin
                dl_addr[dl_n] = dma_addr;
                dl_data[dl_n] = dma_data;
                dl_n++;
            end
            if (irq) irq_cnt++;
        end
    end

    task automatic bus_write(input int idx, input logic [31:0] v);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = 3'(idx);
        reg_wdata = v;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic bus_read(input int idx, output logic [31:0] v);
        @(negedge clk);
        reg_addr = 3'(idx);
        #1;
        v = reg_rdata;
    endtask

    task automatic test_reset();
        logic [31:0] v;
        for (int i = 0; i < 8; i++) begin
            bus_read(i, v);
            chk("R8 reset register clear", v, 32'h0);
        end
        chk("R8 irq low after reset", 32'(irq), 32'h0);
        chk("R8 no write beat after reset", 32'(dma_valid), 32'h0);
        bus_write(4, 32'h1234);
        bus_write(5, 32'h5678);
        bus_read(4, v);
        chk("R8 vertex count ignores writes", v, 32'h0);
        bus_read(5, v);
        chk("R8 last output ignores writes", v, 32'h0);
        bus_write(2, 32'h0000_0007);
        bus_read(2, v);
        chk("R8 last column readback", v, 32'h7);
    endtask

    task automatic run_walk(input string tag, input logic [31:0] base, input int cl, input int rl,
                            input int skip, input int steps, input bit do_stall, input bit poke);
        int npts, k, t, i;
        logic [31:0] v, a, exp_last;
        npts = (cl + 1) * (rl + 1);
        bus_write(1, base);
        bus_write(2, 32'(cl));
        bus_write(3, 32'(rl));
        @(negedge clk);
        stall = do_stall; steps_cfg = steps; skip_pt = skip; armed = 0;
        gl_n = 0; dl_n = 0; irq_cnt = 0; go_cnt = 0;
        bus_write(0, 32'h1);
        bus_read(0, v);
        chk({"R1 busy after start ", tag}, v, 32'h1);
        if (poke) begin
            repeat (5) @(negedge clk);
            bus_write(0, 32'h1);
        end
        t = 0;
        while (irq_cnt == 0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        repeat (30) @(negedge clk);
        chk({"R6 one irq cycle ", tag}, 32'(irq_cnt), 32'h1);
        chk({"R2 point count ", tag}, 32'(go_cnt), 32'(npts));
        chk({"R3 coordinate writes ", tag}, 32'(gl_n), 32'(2 * npts));
        k = 0;
        exp_last = '0;
        for (int y = 0; y <= rl; y++) begin
            for (int x = 0; x <= cl; x++) begin
                i = y * (cl + 1) + x;
                chk({"R3 column to gpr0 ", tag}, {31'b0, gl_idx[2*i]}, 32'h0);
                chk({"R2 column order ", tag}, gl_data[2*i], 32'(x));
                chk({"R3 row to gpr1 ", tag}, {31'b0, gl_idx[2*i+1]}, 32'h1);
                chk({"R2 row order ", tag}, gl_data[2*i+1], 32'(y));
                if (i != skip) begin
                    a = base + 32'(8 * (128 * y + x));
                    chk({"R4 first address ", tag}, dl_addr[2*k], a);
                    chk({"R4 first word big-endian ", tag}, dl_data[2*k], swapped(word_a(x, y)));
                    chk({"R4 second address ", tag}, dl_addr[2*k+1], a + 32'd4);
                    chk({"R4 second word big-endian ", tag}, dl_data[2*k+1], swapped(~word_a(x, y)));
                    exp_last = a + 32'd4;
                    k++;
                end
            end
        end
        chk({"R7 beat count ", tag}, 32'(dl_n), 32'(2 * k));
        bus_read(5, v);
        chk({"R5 last output ", tag}, v, exp_last);
        bus_read(4, v);
        chk({"R6 vertex count ", tag}, v, 32'(npts));
        bus_read(0, v);
        chk({"R1 idle after irq ", tag}, v, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        test_reset();
        run_walk("grid", 32'h1000_0000, 2, 1, -1, 3, 0, 0);
        run_walk("single", 32'h0000_0040, 0, 0, -1, 0, 0, 0);
        run_walk("stalled", 32'h2000_0100, 1, 2, -1, 2, 1, 0);
        run_walk("cutoff", 32'h3000_0000, 1, 1, 2, 1, 0, 0);
        run_walk("restart ignored", 32'h4000_0000, 3, 0, -1, 4, 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule